// File: doc/BRIEF.md
# Accumulator CPU core with on-chip program memory

This block is a tiny 8-bit processor built around an accumulator. Its program and data share a 16-byte memory inside the block. The memory contents are fixed at elaboration through a parameter. All data movement inside the core passes over one internal bus. Besides the accumulator there are four other registers: an operand register that feeds the adder/subtractor, an output register, an instruction register and a 4-bit memory address register. A 4-bit program counter steps through the memory.

Each instruction is one byte. The upper nibble selects the operation and the lower nibble names a memory address. Every instruction takes exactly six clock cycles. Three fetch steps are followed by three execute steps, and a step that an instruction does not use simply idles. The core has no inputs besides clock and reset. The surrounding logic watches the output port, with its one-cycle strobe, and the halted flag.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_data` is cleared to 0, `out_valid` and `halted` are cleared to 0, and the program counter returns to address 0. The core stays in this reset state until the first edge with `rst` low, and execution then starts from address 0.
- R2: Bits [7:4] of an instruction byte are the opcode and bits [3:0] are a memory address.
- R3: Opcode 4'b0000 loads the accumulator with the memory byte at the instruction's address.
- R4: Opcode 4'b0001 copies the addressed memory byte into the operand register. The accumulator then becomes its old value plus that byte, modulo 256.
- R5: Opcode 4'b0010 copies the addressed memory byte into the operand register. The accumulator then becomes its old value minus that byte, modulo 256.
- R6: Opcode 4'b1100 copies the accumulator to `out_data` and raises `out_valid` for exactly one cycle. `out_data` changes at no other time except reset. For every other opcode, `out_valid` stays low.
- R7: Opcode 4'b1111 raises `halted`. After that no register changes and `out_valid` stays low. `halted` stays high until the next reset.
- R8: The opcodes 0011 to 1011, 1101 and 1110 behave as no-operations. The address nibble of the output and halt instructions has no effect.
- R9: The program counter advances by one per instruction fetched and wraps from 15 to 0.
- R10: Instructions take exactly six cycles each. Number the rising edges with `rst` low from 1, and number the instructions executed since reset from 0. The output update of instruction i (`out_valid` high) and the halt of instruction i (`halted` high) are both visible after edge 6i+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| out_data | output | 8 | Output register contents |
| out_valid | output | 1 | One-cycle strobe when the output register is loaded |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench runs a reference model at instruction granularity and compares each output strobe with the accumulator value the model predicts. The strobe must land on edge 6i+4, so a design whose step count is one off, or that fetches from the wrong address, misses the expected cycle or the expected value. The directed program makes the addition wrap past 255 and the subtraction wrap below 0, which exposes a datapath that saturates or carries. It also places an unassigned opcode and a halt with a nonzero address nibble. A second image, drawn by a fixed-seed generator, has no halt, so execution runs through memory several times. A program counter that does not wrap, or that stalls, then shows up as a wrong output sequence. After the halt and after a later reset, the bench checks that the output stays still and that the halted flag holds and then clears.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPW   = 4;
  localparam int NSTEP = 6;

  // step positions in the one-hot sequencer
  localparam int ST_ADDR  = 0;  // MAR <- PC
  localparam int ST_FETCH = 1;  // IR <- mem, PC++
  localparam int ST_DEC   = 2;  // decode, idle
  localparam int ST_EX1   = 3;
  localparam int ST_EX2   = 4;
  localparam int ST_EX3   = 5;

  localparam logic [OPW-1:0] OP_LDA = 4'b0000;
  localparam logic [OPW-1:0] OP_ADD = 4'b0001;
  localparam logic [OPW-1:0] OP_SUB = 4'b0010;
  localparam logic [OPW-1:0] OP_OUT = 4'b1100;
  localparam logic [OPW-1:0] OP_HLT = 4'b1111;
endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [DW*(2**AW)-1:0] INIT = '0
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i*DW +: DW];
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq #(
  parameter int NSTEP = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_req,
  output logic [NSTEP-1:0] step,
  output logic             halted
);
  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= NSTEP'(1);
      halted <= 1'b0;
    end else if (!halted) begin
      if (halt_req) halted <= 1'b1;
      else          step   <= {step[NSTEP-2:0], step[NSTEP-1]};
    end
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);
  assign y = sub ? (a - b) : (a + b);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [DW*(2**AW)-1:0] INIT =
    128'h0000_0025_3020_F0F5_C01C_C02B_C7E3_1A09
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          halted
);
  localparam int ZW = DW - AW;

  logic [AW-1:0]    pc, mar;
  logic [DW-1:0]    ir, acc, breg, rdata, alu_y, bus;
  logic [NSTEP-1:0] step;
  logic [OPW-1:0]   opcode;
  logic             is_mem_op, halt_req;

  assign opcode    = ir[DW-1 -: OPW];
  assign is_mem_op = (opcode == OP_LDA) || (opcode == OP_ADD) || (opcode == OP_SUB);
  assign halt_req  = step[ST_EX1] && (opcode == OP_HLT);

  acc_cpu_mem #(.DW(DW), .AW(AW), .INIT(INIT)) u_mem (
    .addr (mar),
    .rdata(rdata)
  );

  acc_cpu_seq #(.NSTEP(NSTEP)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .halt_req(halt_req),
    .step    (step),
    .halted  (halted)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .a  (acc),
    .b  (breg),
    .sub(opcode == OP_SUB),
    .y  (alu_y)
  );

  // single shared bus: one source per step
  always_comb begin
    if (step[ST_ADDR])                     bus = {{ZW{1'b0}}, pc};
    else if (step[ST_FETCH] || step[ST_EX2]) bus = rdata;
    else if (step[ST_EX1] && opcode == OP_OUT) bus = acc;
    else if (step[ST_EX1])                 bus = {{ZW{1'b0}}, ir[AW-1:0]};
    else                                   bus = alu_y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      mar       <= '0;
      ir        <= '0;
      acc       <= '0;
      breg      <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (!halted) begin
      out_valid <= 1'b0;
      if (step[ST_ADDR]) mar <= bus[AW-1:0];
      if (step[ST_FETCH]) begin
        ir <= bus;
        pc <= pc + 1'b1;
      end
      if (step[ST_EX1]) begin
        if (is_mem_op) mar <= bus[AW-1:0];
        if (opcode == OP_OUT) begin
          out_data  <= bus;
          out_valid <= 1'b1;
        end
      end
      if (step[ST_EX2]) begin
        if (opcode == OP_LDA) acc <= bus;
        if (opcode == OP_ADD || opcode == OP_SUB) breg <= bus;
      end
      if (step[ST_EX3] && (opcode == OP_ADD || opcode == OP_SUB)) acc <= bus;
    end
  end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int NSTEP = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [DW-1:0]    out_data,
  input logic             out_valid,
  input logic             halted,
  input logic [NSTEP-1:0] step,
  input logic [AW-1:0]    pc
);
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R7
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> !out_valid); // R7
  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(step) == 1); // R10
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step[1] && !halted) |=> pc == AW'($past(pc) + 1'b1)); // R9
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step[1] |=> $stable(pc)); // R9
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .AW(AW), .NSTEP(acc_cpu_pkg::NSTEP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .out_data (out_data),
  .out_valid(out_valid),
  .halted   (halted),
  .step     (step),
  .pc       (pc)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  localparam int NI = 2;

  // directed image: wrap-around add/sub, unassigned opcode, OUT/HLT with nonzero nibbles
  localparam logic [127:0] PROG_A = 128'h0000_0025_3020_F0F5_C01C_C02B_C7E3_1A09;

  // fixed-seed generated image without halt (exercises PC wrap)
  function automatic logic [127:0] gen_prog(input logic [31:0] seed);
    logic [127:0] img;
    logic [31:0]  s;
    logic [3:0]   op;
    s   = seed;
    img = '0;
    for (int a = 0; a < 16; a++) begin
      s = s * 32'd1103515245 + 32'd12345;
      case ((s >> 16) % 6)
        0: op = 4'h0;
        1: op = 4'h1;
        2: op = 4'h2;
        3: op = 4'hC;
        4: op = 4'hC;
        default: op = 4'h7;
      endcase
      img[a*8 +: 8] = {op, s[27:24]};
    end
    return img;
  endfunction

  localparam logic [127:0] PROG_B = gen_prog(32'd20240607);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [7:0] o_data [NI];
  logic       o_vld  [NI];
  logic       o_hlt  [NI];

  acc_cpu #(.INIT(PROG_A)) dut (
    .clk(clk), .rst(rst), .out_data(o_data[0]), .out_valid(o_vld[0]), .halted(o_hlt[0]));
  acc_cpu #(.INIT(PROG_B)) dut_rnd (
    .clk(clk), .rst(rst), .out_data(o_data[1]), .out_valid(o_vld[1]), .halted(o_hlt[1]));

  int unsigned n_run = 0, n_fail = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  logic [7:0] img   [NI][16];
  logic [3:0] pc_m  [NI];
  logic [7:0] acc_m [NI];
  logic [7:0] out_m [NI];
  logic       hlt_m [NI];

  task automatic chk(input bit ok, input string req, input int k, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s inst%0d cyc=%0d actual=%0h expected=%0h", req, k, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NI; k++) begin
      pc_m[k] = 0; acc_m[k] = 0; out_m[k] = 0; hlt_m[k] = 0;
    end
  endtask

  // executes one instruction of instance k and checks the ports after edge 6i+4
  task automatic step_model(input int k);
    logic [7:0] ins, opd;
    logic       vld_exp;
    ins = img[k][pc_m[k]];
    pc_m[k] = pc_m[k] + 1;                        // R9 wrap in 4 bits
    opd = img[k][ins[3:0]];                       // R2 address field
    vld_exp = 1'b0;
    case (ins[7:4])
      4'h0: acc_m[k] = opd;                       // R3
      4'h1: acc_m[k] = acc_m[k] + opd;            // R4
      4'h2: acc_m[k] = acc_m[k] - opd;            // R5
      4'hC: begin out_m[k] = acc_m[k]; vld_exp = 1'b1; end // R6
      4'hF: hlt_m[k] = 1'b1;                      // R7
      default: ;                                  // R8
    endcase
    chk(o_vld[k] == vld_exp, "R6/R10 strobe", k, o_vld[k], vld_exp);
    chk(o_data[k] == out_m[k], "R3/R4/R5/R6 out_data", k, o_data[k], out_m[k]);
    chk(o_hlt[k] == hlt_m[k], "R7/R10 halted", k, o_hlt[k], hlt_m[k]);
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int k = 0; k < NI; k++) begin
        if (hlt_m[k]) begin
          chk(o_hlt[k] == 1'b1, "R7 halted sticky", k, o_hlt[k], 1);
          chk(o_vld[k] == 1'b0, "R7 no strobe", k, o_vld[k], 0);
          chk(o_data[k] == out_m[k], "R7 out frozen", k, o_data[k], out_m[k]);
        end else if (cyc % 6 == 4) begin
          step_model(k);
        end else begin
          chk(o_vld[k] == 1'b0, "R10 strobe off-step", k, o_vld[k], 0);
          chk(o_hlt[k] == 1'b0, "R10 halted early", k, o_hlt[k], 0);
          chk(o_data[k] == out_m[k], "R6 out hold", k, o_data[k], out_m[k]);
        end
      end
    end
  endtask

  task automatic reset_check();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      chk(o_data[k] == 8'h00, "R1 out_data", k, o_data[k], 0);
      chk(o_vld[k] == 1'b0, "R1 out_valid", k, o_vld[k], 0);
      chk(o_hlt[k] == 1'b0, "R1 halted", k, o_hlt[k], 0);
    end
    model_reset();
    rst = 1'b0;
  endtask

  initial begin
    for (int a = 0; a < 16; a++) begin
      img[0][a] = PROG_A[a*8 +: 8];
      img[1][a] = PROG_B[a*8 +: 8];
    end
    model_reset();
    @(negedge clk);
    reset_check();
    run_cycles(700);   // directed halts early; generated image wraps PC several times
    reset_check();     // R1: reset clears the halt
    run_cycles(120);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule